// File: doc/BRIEF.md
# Synchronous Two-Phase Current Chopper

This block turns a digitized over-current indication into switching commands for the low-side switches of a unipolar stepper winding set. One divided timebase creates a fixed chopping period that all phases share. At the first cycle of every period each phase's on-latch is armed, so the switch of the selected winding half conducts. When that phase's current comparator (already synchronous to `clk`) reports that the winding current has reached its reference, the latch clears and the switch stays off until the next period begins.

Comparator edges caused by switching spikes are masked for a programmable number of cycles right after the period start. A direction bit per phase selects which of the two complementary winding halves is driven. Whenever that bit changes, both halves of the pair are held off for a programmable dead interval before the new half may conduct. A global enable cuts every switch output at once, without disturbing the timebase or the latches. With the defaults at a 200 MHz clock, the period is about 45 kHz and the dead interval is 3.75 µs.

Top module: `pwm_chop_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every `gate_p` and `gate_n` bit is 0.
- R2: The period counter starts at 0 on reset release and wraps after `PERIOD_CYC` cycles. A phase whose latch is set and that sees no trip drives its gate from cycle 1 of the period through cycle 0 of the following period. All phases turn on in the same cycle.
- R3: A trip seen when the period count is above `BLANK_CYC` clears that phase's latch at the clock edge. The gate is low from the next cycle until the next period sets the latch again.
- R4: A trip seen at period counts 1 through `BLANK_CYC` has no effect: the gate stays on in the following cycle.
- R5: A trip in count 0, the cycle that arms the latch, wins over the arm. A trip held high from count 0 keeps the gate low for the whole period.
- R6: When `dir[i]` changes, both `gate_p[i]` and `gate_n[i]` are low in the cycle of the change and in the `DEAD_CYC` cycles that follow.
- R7: `gate_p[i]` and `gate_n[i]` are never high in the same cycle.
- R8: When `enable` is low, all gate outputs are low in that same cycle. The timebase, the latches and the dead-interval timers keep running, so the outputs resume from their current state once `enable` returns.
- R9: Polarity: `dir[i]`=0 drives `gate_p[i]`, and `dir[i]`=1 drives `gate_n[i]`.
- R10: Each phase's latch responds only to its own `trip` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Output enable; low forces all gates off |
| dir | input | NUM_PHASES | Winding-half select per phase |
| trip | input | NUM_PHASES | Synchronous current-at-reference flag per phase |
| gate_p | output | NUM_PHASES | Switch command, first winding half |
| gate_n | output | NUM_PHASES | Switch command, complementary winding half |

## Verification
The period arm and a comparator trip can land in the same cycle. The latch must clear in that case. The bench provokes this by sweeping a single-cycle trip across every count of the period, including count 0 and the last count. A further case holds the trip high from count 0 for a whole period. Each case is judged against a per-cycle arithmetic expectation of the gate levels, and the blanking counts are part of the same sweep. A direction change can also coincide with a period arm or a trip; a second sweep moves the toggle across every count and checks both gates of the pair each cycle.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;
   // Defaults sized for a 200 MHz system clock.
   localparam int unsigned DEF_PERIOD_CYC = 4444; // about 45 kHz chopping
   localparam int unsigned DEF_BLANK_CYC  = 40;   // 200 ns spike mask
   localparam int unsigned DEF_DEAD_CYC   = 750;  // 3.75 us non-overlap

   typedef struct packed {
      logic p;
      logic n;
   } gate_pair_t;

   function automatic int unsigned cnt_width(input int unsigned states);
      return (states > 2) ? $clog2(states) : 1;
   endfunction
endpackage

// File: rtl/chop_timebase.sv
`timescale 1ns/1ps
module chop_timebase #(
   parameter int unsigned PERIOD_CYC = chop_pkg::DEF_PERIOD_CYC,
   parameter int unsigned BLANK_CYC  = chop_pkg::DEF_BLANK_CYC
) (
   input  logic clk,
   input  logic rst_n,
   output logic period_start,
   output logic trip_accept
);
   localparam int unsigned CW = chop_pkg::cnt_width(PERIOD_CYC);
   localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (cnt_q == LAST)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + CW'(1);
   end

   assign period_start = (cnt_q == '0);

   generate
      if (BLANK_CYC == 0) begin : g_noblank
         assign trip_accept = 1'b1;
      end else begin : g_blank
         localparam logic [CW-1:0] BLANK_END = CW'(BLANK_CYC);
         // count 0 is sampled so that a pre-existing trip wins over the arm
         assign trip_accept = period_start | (cnt_q > BLANK_END);
      end
   endgenerate
endmodule

// File: rtl/chop_latch.sv
`timescale 1ns/1ps
module chop_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic trip_i,
   input  logic accept_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  q_o <= 1'b0;
      else if (trip_i && accept_i) q_o <= 1'b0;
      else if (set_i)              q_o <= 1'b1;
   end
endmodule

// File: rtl/chop_deadband.sv
`timescale 1ns/1ps
module chop_deadband #(
   parameter int unsigned DEAD_CYC = chop_pkg::DEF_DEAD_CYC
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                on_i,
   input  logic                dir_i,
   output chop_pkg::gate_pair_t gate_o
);
   logic side_q;
   logic settled;

   generate
      if (DEAD_CYC == 0) begin : g_nodead
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) side_q <= 1'b0;
            else        side_q <= dir_i;
         end
         assign settled = (dir_i == side_q);
      end else begin : g_dead
         localparam int unsigned DW = chop_pkg::cnt_width(DEAD_CYC + 1);
         localparam logic [DW-1:0] DLOAD = DW'(DEAD_CYC);
         logic [DW-1:0] dcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               side_q <= 1'b0;
               dcnt_q <= '0;
            end else if (dir_i != side_q) begin
               side_q <= dir_i;
               dcnt_q <= DLOAD;
            end else if (dcnt_q != '0) begin
               dcnt_q <= dcnt_q - DW'(1);
            end
         end
         assign settled = (dir_i == side_q) && (dcnt_q == '0);
      end
   endgenerate

   assign gate_o.p = on_i & settled & ~side_q;
   assign gate_o.n = on_i & settled &  side_q;
endmodule

// File: rtl/pwm_chop_ctrl.sv
`timescale 1ns/1ps
module pwm_chop_ctrl #(
   parameter int unsigned NUM_PHASES = 2,
   parameter int unsigned PERIOD_CYC = chop_pkg::DEF_PERIOD_CYC,
   parameter int unsigned BLANK_CYC  = chop_pkg::DEF_BLANK_CYC,
   parameter int unsigned DEAD_CYC   = chop_pkg::DEF_DEAD_CYC
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  enable,
   input  logic [NUM_PHASES-1:0] dir,
   input  logic [NUM_PHASES-1:0] trip,
   output logic [NUM_PHASES-1:0] gate_p,
   output logic [NUM_PHASES-1:0] gate_n
);
   generate
      if (NUM_PHASES < 1) begin : g_bad_phases
         $error("NUM_PHASES must be at least 1");
      end
      if (PERIOD_CYC < 4) begin : g_bad_period
         $error("PERIOD_CYC must be at least 4");
      end
      if (BLANK_CYC + 2 > PERIOD_CYC) begin : g_bad_blank
         $error("BLANK_CYC must leave at least one unmasked count");
      end
   endgenerate

   logic period_start;
   logic trip_accept;

   chop_timebase #(
      .PERIOD_CYC(PERIOD_CYC),
      .BLANK_CYC (BLANK_CYC)
   ) u_timebase (
      .clk         (clk),
      .rst_n       (rst_n),
      .period_start(period_start),
      .trip_accept (trip_accept)
   );

   generate
      for (genvar i = 0; i < NUM_PHASES; i++) begin : g_phase
         logic                 lat_q;
         chop_pkg::gate_pair_t pair;

         chop_latch u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (period_start),
            .trip_i  (trip[i]),
            .accept_i(trip_accept),
            .q_o     (lat_q)
         );

         chop_deadband #(.DEAD_CYC(DEAD_CYC)) u_dead (
            .clk   (clk),
            .rst_n (rst_n),
            .on_i  (lat_q & enable),
            .dir_i (dir[i]),
            .gate_o(pair)
         );

         assign gate_p[i] = pair.p;
         assign gate_n[i] = pair.n;
      end
   endgenerate
endmodule

// File: rtl/chop_checker.sv
`timescale 1ns/1ps
module chop_checker #(
   parameter int unsigned NUM_PHASES = 2,
   parameter int unsigned PERIOD_CYC = chop_pkg::DEF_PERIOD_CYC,
   parameter int unsigned BLANK_CYC  = chop_pkg::DEF_BLANK_CYC,
   parameter int unsigned DEAD_CYC   = chop_pkg::DEF_DEAD_CYC
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  enable,
   input logic [NUM_PHASES-1:0] dir,
   input logic [NUM_PHASES-1:0] trip,
   input logic [NUM_PHASES-1:0] gate_p,
   input logic [NUM_PHASES-1:0] gate_n
);
   localparam int unsigned CW = chop_pkg::cnt_width(PERIOD_CYC);
   localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);
   localparam logic [CW-1:0] BEND = CW'(BLANK_CYC);

   // independent cycle-in-period tracker
   logic [CW-1:0] ck_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ck_cnt <= '0;
      else if (ck_cnt == LAST) ck_cnt <= '0;
      else                     ck_cnt <= ck_cnt + CW'(1);
   end

   logic in_mask;
   logic trip_live;
   assign in_mask   = (ck_cnt != '0) && (ck_cnt <= BEND);
   assign trip_live = !in_mask;

   AST_ENABLE_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> ((gate_p | gate_n) == '0)); // R8

   AST_NO_SHOOT_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_p & gate_n) == '0); // R7

   generate
      for (genvar i = 0; i < NUM_PHASES; i++) begin : g_ph
         AST_TRIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (trip_live && trip[i]) |=> !(gate_p[i] | gate_n[i])); // R3

         AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (in_mask && (gate_p[i] | gate_n[i]))
            |=> ((gate_p[i] | gate_n[i]) || !enable || (dir[i] != $past(dir[i])))); // R4

         if (DEAD_CYC > 0) begin : g_gap
            AST_GAP_AFTER_P: assert property (@(posedge clk) disable iff (!rst_n)
               $fell(gate_p[i]) |=> !gate_n[i]); // R6
            AST_GAP_AFTER_N: assert property (@(posedge clk) disable iff (!rst_n)
               $fell(gate_n[i]) |=> !gate_p[i]); // R6
         end
      end
   endgenerate
endmodule

bind pwm_chop_ctrl chop_checker #(
   .NUM_PHASES(NUM_PHASES),
   .PERIOD_CYC(PERIOD_CYC),
   .BLANK_CYC (BLANK_CYC),
   .DEAD_CYC  (DEAD_CYC)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .enable(enable),
   .dir   (dir),
   .trip  (trip),
   .gate_p(gate_p),
   .gate_n(gate_n)
);

// File: tb/pwm_chop_ctrl_tb.sv
`timescale 1ns/1ps
module pwm_chop_ctrl_tb;
   localparam int P = 16;
   localparam int B = 3;
   localparam int D = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [1:0] dir = 2'b00;
   logic [1:0] trip = 2'b00;
   logic [1:0] gate_p;
   logic [1:0] gate_n;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // expectation state derived from the requirements
   int   m_cnt;
   logic m_lat [2];
   logic m_side[2];
   int   m_dc  [2];

   always #2.5 clk = ~clk;

   pwm_chop_ctrl #(
      .NUM_PHASES(2),
      .PERIOD_CYC(P),
      .BLANK_CYC (B),
      .DEAD_CYC  (D)
   ) u_dut (
      .clk   (clk),
      .rst_n (rst_n),
      .enable(enable),
      .dir   (dir),
      .trip  (trip),
      .gate_p(gate_p),
      .gate_n(gate_n)
   );

   task automatic cmp(input string tag, input int ph, input logic [1:0] act, input logic [1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s phase %0d: got p/n=%b expected %b at t=%0t", tag, ph, act, exp, $time);
      end
   endtask

   // drive one cycle (called just after a falling edge), compare, advance
   task automatic step(input logic en, input logic [1:0] dv, input logic [1:0] tv,
                       input string tag_a, input string tag_b);
      enable = en;
      dir    = dv;
      trip   = tv;
      #1;
      for (int i = 0; i < 2; i++) begin
         logic       on;
         logic       ok;
         logic [1:0] e;
         on = m_lat[i] & en;
         ok = (m_dc[i] == 0) && (dv[i] == m_side[i]);
         e  = {on & ok & ~m_side[i], on & ok & m_side[i]};
         cmp((i == 0) ? tag_a : tag_b, i, {gate_p[i], gate_n[i]}, e);
         cmp("R7", i, {1'b0, gate_p[i] & gate_n[i]}, 2'b00);
      end
      @(posedge clk);
      for (int i = 0; i < 2; i++) begin
         if (tv[i] && (m_cnt == 0 || m_cnt > B)) m_lat[i] = 1'b0;
         else if (m_cnt == 0)                     m_lat[i] = 1'b1;
         if (dv[i] != m_side[i]) begin
            m_side[i] = dv[i];
            m_dc[i]   = D;
         end else if (m_dc[i] != 0) begin
            m_dc[i] = m_dc[i] - 1;
         end
      end
      m_cnt = (m_cnt + 1) % P;
      @(negedge clk);
   endtask

   initial begin
      logic [1:0] dcur;
      enable = 1'b1;
      dir    = 2'b01;
      repeat (3) begin
         @(negedge clk);
         cmp("R1", 0, {gate_p[0], gate_n[0]}, 2'b00);
         cmp("R1", 1, {gate_p[1], gate_n[1]}, 2'b00);
      end
      dir = 2'b00;
      m_cnt = 0;
      for (int i = 0; i < 2; i++) begin
         m_lat[i] = 1'b0;
         m_side[i] = 1'b0;
         m_dc[i] = 0;
      end
      rst_n = 1'b1;

      // plain chopping without trips, first cycle covers R1 too
      for (int c = 0; c < 2 * P; c++) step(1'b1, 2'b00, 2'b00, (c == 0) ? "R1" : "R2", "R2");

      // single-cycle trip swept over every count; phase B mirrored
      for (int t = 0; t < P; t++) begin
         for (int c = 0; c < P; c++) begin
            step(1'b1, 2'b00, {1'(c == P - 1 - t), 1'(c == t)},
                 (t == 0) ? "R5" : ((t <= B) ? "R4" : "R3"), "R10");
         end
      end
      for (int c = 0; c < P; c++) step(1'b1, 2'b00, 2'b00, "R2", "R2");

      // trip held from the arming cycle through the period
      for (int c = 0; c < P; c++) step(1'b1, 2'b00, 2'b01, "R5", "R10");
      for (int c = 0; c < P; c++) step(1'b1, 2'b00, 2'b00, "R2", "R2");

      // polarity on B, direction toggle on A swept across the period
      dcur = 2'b10;
      for (int c = 0; c < P; c++) step(1'b1, dcur, 2'b00, "R2", "R9");
      for (int t = 0; t < P; t++) begin
         for (int c = 0; c < P; c++) begin
            if (c == t) dcur[0] = ~dcur[0];
            step(1'b1, dcur, 2'b00, "R6", "R9");
         end
      end

      // enable dropped for three cycles at every offset
      for (int t = 0; t < P; t++) begin
         for (int c = 0; c < P; c++) begin
            step(!(c >= t && c < t + 3), dcur, {1'(c == 9), 1'b0}, "R8", "R8");
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(100000 * 5);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R2 watchdog: got no completion expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule